// File: doc/BRIEF.md
# Channel Pattern and Edge Trigger

This block watches a 32-channel sample word, split into four groups of eight channels, and decides when a capture should start. Each channel can be told to require a high level, to require a low level, or to be ignored. On top of the level pattern, one channel can be picked to require a rising edge, a falling edge or any change between the previous sample and the current one. A condition that holds on a sample is a match. Once a programmable number of matches has been seen, the block raises a single-cycle trigger pulse and sets a flag that stays high.

Configuration comes through a byte-wide write port. Eight bytes hold the level conditions, at two bits per channel. One byte holds the edge mode together with the index of the edge channel. Two bytes hold the 16-bit occurrence count.

After reset the block is disarmed. An `arm` strobe starts a hunt, clears the match counter, and also re-arms the block after it has fired. Samples are taken on every clock.

The control logic is a four-state machine:
- `ST_IDLE`: disarmed after reset. The only transition is arm, which leads to `ST_HUNT`.
- `ST_HUNT`: counts matches. Arm restarts the count and stays in `ST_HUNT`. The final match leads to `ST_FIRE`.
- `ST_FIRE`: lasts exactly one cycle. Arm leads to `ST_HUNT`; otherwise the next state is `ST_HOLD`.
- `ST_HOLD`: fired and waiting. Arm leads to `ST_HUNT`.

Top module: `chan_trigger`

## Requirements
- R1: After reset, `trig_pulse` and `triggered` are 0. All level bytes and the edge byte are 0, and the occurrence count is 1.
- R2: Configuration addresses work as follows:
  - Address 2g+k (g = group 0..3, k = 0 for channels 0..3 and k = 1 for channels 4..7 of the group) holds the level byte for those four channels.
  - For local channel n within that byte (n = channel mod 4), bit 2n requires high and bit 2n+1 requires low.
  - Writes to addresses 11..15 change nothing.
- R3: A channel whose two level bits are both clear does not affect matching.
- R4: A channel with both level bits set can never match, so the block never fires while that setting is in place.
- R5: At address 8, bits 7:6 select the edge mode: 01 is rising, 10 is falling, 11 is either edge. Bits 4:0 select the edge channel as group*8 + channel. An edge on any other channel is not seen.
- R6: With edge mode 00, matching depends only on the level pattern, whatever the channel-index bits hold.
- R7: An edge is judged between the sample of the previous clock and the current one. The previous sample is updated on every clock, including cycles with `arm` high.
- R8: Address 9 holds the low byte of the occurrence count and address 10 the high byte. A count of 0 behaves like 1.
- R9: On the clock edge where the Nth match since arming is sampled (N = count), the block moves so that in the following cycle `trig_pulse` is high for exactly one cycle and `triggered` goes high.
- R10: Once fired, `triggered` stays high and further matches produce no pulse until `arm`. `arm` clears the match counter. A match sampled together with `arm` is not counted.
- R11: Before the first `arm` after reset, matches are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration byte address |
| cfg_wdata | input | 8 | Configuration write data |
| arm | input | 1 | Start or restart a hunt and clear the match counter |
| sample | input | 32 | Channel sample word (group g occupies bits 8g+7..8g) |
| trig_pulse | output | 1 | One-cycle trigger pulse |
| triggered | output | 1 | Sticky fired flag |

## Verification
The hardest situation to reach from the ports is firing on a count above 255, because it needs the high count byte and a long run of matches with no early pulse. The bench programs a count of 258 and feeds 257 matching samples, expecting silence, and then one more, expecting the pulse. A second subtle case is the boundary between arming and counting. Here the bench holds a matching sample through the arm cycle and checks that the pulse arrives one match later than it would if that cycle had counted. It also checks that an edge which appears across the arm cycle is not reported afterwards. The edge sweep drives a decoy transition on a neighbouring channel before the real one, for every channel and every mode.

// File: rtl/ct_pkg.sv
package ct_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HUNT = 2'd1,
        ST_FIRE = 2'd2,
        ST_HOLD = 2'd3
    } trig_state_e;

    typedef enum logic [1:0] {
        EDGE_NONE = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_ANY  = 2'b11
    } edge_mode_e;

endpackage

// File: rtl/ct_cfg_regs.sv
module ct_cfg_regs #(
    parameter int NLVL   = 8,
    parameter int IDX_W  = 5,
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [7:0]               wdata,
    output logic [NLVL*8-1:0]        lvl_flat,
    output ct_pkg::edge_mode_e       edge_mode,
    output logic [IDX_W-1:0]         edge_idx,
    output logic [CNT_W-1:0]         occ_count
);
    import ct_pkg::*;

    localparam int CNT_BYTES = CNT_W / 8;
    localparam int A_EDGE    = NLVL;
    localparam int A_CNT0    = NLVL + 1;

    // Level condition bytes, one flop group per address
    for (genvar r = 0; r < NLVL; r++) begin : g_lvl
        always_ff @(posedge clk) begin
            if (!rst_n)
                lvl_flat[r*8 +: 8] <= '0;
            else if (we && addr == ADDR_W'(r))
                lvl_flat[r*8 +: 8] <= wdata;
        end
    end

    // Edge mode and channel index share one address
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            edge_mode <= EDGE_NONE;
            edge_idx  <= '0;
        end else if (we && addr == ADDR_W'(A_EDGE)) begin
            edge_mode <= edge_mode_e'(wdata[7:6]);
            edge_idx  <= wdata[IDX_W-1:0];
        end
    end

    // Occurrence count, low byte first; reset value is one
    for (genvar b = 0; b < CNT_BYTES; b++) begin : g_cnt
        always_ff @(posedge clk) begin
            if (!rst_n)
                occ_count[b*8 +: 8] <= (b == 0) ? 8'd1 : 8'd0;
            else if (we && addr == ADDR_W'(A_CNT0 + b))
                occ_count[b*8 +: 8] <= wdata;
        end
    end

endmodule

// File: rtl/ct_level_match.sv
module ct_level_match #(
    parameter int GROUPS  = 4,
    parameter int GROUP_W = 8,
    parameter int NCH     = GROUPS * GROUP_W,
    parameter int NLVL    = NCH / 4
) (
    input  logic [NCH-1:0]      sample,
    input  logic [NLVL*8-1:0]   lvl_flat,
    output logic                lvl_ok
);
    localparam int RPG = GROUP_W / 4;   // level bytes per group

    logic [NCH-1:0] chan_ok;

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        localparam int GRP = c / GROUP_W;
        localparam int LOC = c % GROUP_W;
        localparam int REG = GRP * RPG + LOC / 4;
        localparam int BIT = REG * 8 + 2 * (LOC % 4);
        logic need_hi, need_lo;
        assign need_hi = lvl_flat[BIT];
        assign need_lo = lvl_flat[BIT + 1];
        // both bits set leaves no sample value that satisfies the channel
        assign chan_ok[c] = !(need_hi && !sample[c]) && !(need_lo && sample[c]);
    end

    assign lvl_ok = &chan_ok;

endmodule

// File: rtl/ct_edge_detect.sv
module ct_edge_detect #(
    parameter int NCH   = 32,
    parameter int IDX_W = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NCH-1:0]       sample,
    input  ct_pkg::edge_mode_e   edge_mode,
    input  logic [IDX_W-1:0]     edge_idx,
    output logic                 edge_ok
);
    import ct_pkg::*;

    logic [NCH-1:0] prev_q;
    logic           cur_bit, old_bit;

    // history register follows the bus every cycle
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= sample;
    end

    assign cur_bit = sample[edge_idx];
    assign old_bit = prev_q[edge_idx];

    always_comb begin
        unique case (edge_mode)
            EDGE_NONE: edge_ok = 1'b1;
            EDGE_RISE: edge_ok = !old_bit && cur_bit;
            EDGE_FALL: edge_ok = old_bit && !cur_bit;
            EDGE_ANY:  edge_ok = old_bit ^ cur_bit;
        endcase
    end

endmodule

// File: rtl/chan_trigger.sv
module chan_trigger #(
    parameter  int GROUPS  = 4,
    parameter  int GROUP_W = 8,
    parameter  int CNT_W   = 16,
    localparam int NCH     = GROUPS * GROUP_W,
    localparam int NLVL    = NCH / 4,
    localparam int IDX_W   = $clog2(NCH),
    localparam int ADDR_W  = $clog2(NLVL + 1 + CNT_W / 8)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [ADDR_W-1:0]  cfg_addr,
    input  logic [7:0]         cfg_wdata,
    input  logic               arm,
    input  logic [NCH-1:0]     sample,
    output logic               trig_pulse,
    output logic               triggered
);
    import ct_pkg::*;

    logic [NLVL*8-1:0] lvl_flat;
    edge_mode_e        edge_mode;
    logic [IDX_W-1:0]  edge_idx;
    logic [CNT_W-1:0]  occ_count;
    logic              lvl_ok, edge_ok, cond_hit, last_hit;

    trig_state_e       state_q, state_d;
    logic [CNT_W-1:0]  hits_q, hits_d;

    ct_cfg_regs #(
        .NLVL(NLVL), .IDX_W(IDX_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W)
    ) cfg_i (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
        .wdata(cfg_wdata), .lvl_flat(lvl_flat), .edge_mode(edge_mode),
        .edge_idx(edge_idx), .occ_count(occ_count)
    );

    ct_level_match #(
        .GROUPS(GROUPS), .GROUP_W(GROUP_W), .NCH(NCH), .NLVL(NLVL)
    ) lvl_i (
        .sample(sample), .lvl_flat(lvl_flat), .lvl_ok(lvl_ok)
    );

    ct_edge_detect #(
        .NCH(NCH), .IDX_W(IDX_W)
    ) edge_i (
        .clk(clk), .rst_n(rst_n), .sample(sample), .edge_mode(edge_mode),
        .edge_idx(edge_idx), .edge_ok(edge_ok)
    );

    assign cond_hit = lvl_ok && edge_ok;
    // count of zero is satisfied by the first match, same as one
    assign last_hit = ({1'b0, hits_q} + 1'b1) >= {1'b0, occ_count};

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            hits_q  <= '0;
        end else begin
            state_q <= state_d;
            hits_q  <= hits_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        hits_d  = hits_q;
        unique case (state_q)
            ST_IDLE: begin
                if (arm) begin
                    state_d = ST_HUNT;
                    hits_d  = '0;
                end
            end
            ST_HUNT: begin
                if (arm) begin
                    hits_d = '0;
                end else if (cond_hit) begin
                    if (last_hit) state_d = ST_FIRE;
                    else          hits_d  = hits_q + 1'b1;
                end
            end
            ST_FIRE: begin
                if (arm) begin
                    state_d = ST_HUNT;
                    hits_d  = '0;
                end else begin
                    state_d = ST_HOLD;
                end
            end
            ST_HOLD: begin
                if (arm) begin
                    state_d = ST_HUNT;
                    hits_d  = '0;
                end
            end
        endcase
    end

    // outputs decoded from state
    always_comb begin
        trig_pulse = (state_q == ST_FIRE);
        triggered  = (state_q == ST_FIRE) || (state_q == ST_HOLD);
    end

endmodule

// File: rtl/ct_checker.sv
module ct_checker (
    input logic clk,
    input logic rst_n,
    input logic arm,
    input logic hit,
    input logic trig_pulse,
    input logic triggered
);
    // R9: pulse lasts one cycle
    a_r9_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
        trig_pulse |=> !trig_pulse);

    // R9: pulse comes with the flag
    a_r9_pulse_flag: assert property (@(posedge clk) disable iff (!rst_n)
        trig_pulse |-> triggered);

    // R9: flag rises only together with a pulse
    a_r9_rise_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(triggered) |-> trig_pulse);

    // R9, R10: a pulse follows a match sampled without arm
    a_r10_pulse_cause: assert property (@(posedge clk) disable iff (!rst_n)
        trig_pulse |-> $past(hit && !arm));

    // R10: flag is sticky until arm
    a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (triggered && !arm) |=> triggered);

    // R10: arm clears the flag
    a_r10_arm_clears: assert property (@(posedge clk) disable iff (!rst_n)
        arm |=> !triggered);

endmodule

bind chan_trigger ct_checker chk_i (
    .clk(clk), .rst_n(rst_n), .arm(arm), .hit(cond_hit),
    .trig_pulse(trig_pulse), .triggered(triggered)
);

// File: tb/chan_trigger_tb_top.sv
module chan_trigger_tb_top;
    localparam int CLK_NS = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [7:0]  cfg_wdata = '0;
    logic        arm = 1'b0;
    logic [31:0] smp = '0;
    logic        trig_pulse, triggered;

    int n_chk = 0;
    int n_err = 0;

    chan_trigger dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .arm(arm), .sample(smp),
        .trig_pulse(trig_pulse), .triggered(triggered)
    );

    always #(CLK_NS/2) clk = ~clk;

    task automatic check(logic got, logic exp, string what);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0b expected %0b", what, got, exp);
        end
    endtask

    task automatic wr(int a, int d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a[3:0]; cfg_wdata = d[7:0];
        @(posedge clk); #1;
        cfg_we = 1'b0;
    endtask

    task automatic clear_cfg();
        for (int r = 0; r < 9; r++) wr(r, 0);
        wr(9, 1);
        wr(10, 0);
    endtask

    task automatic do_arm();
        @(negedge clk); arm = 1'b1;
        @(posedge clk); #1; arm = 1'b0;
    endtask

    task automatic step(logic [31:0] s);
        @(negedge clk); smp = s;
        @(posedge clk); #1;
    endtask

    function automatic int lvl_reg(int c);
        return (c / 8) * 2 + ((c % 8) / 4);
    endfunction

    function automatic int lvl_bit(int c, int low);
        return 2 * (c % 4) + low;
    endfunction

    initial begin
        repeat (CLK_NS * 200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        check(trig_pulse, 1'b0, "R1 reset pulse");
        check(triggered, 1'b0, "R1 reset flag");

        // R11: default config matches every sample, but block is disarmed
        for (int i = 0; i < 4; i++) step(32'h1 << i);
        check(triggered, 1'b0, "R11 idle ignores matches");
        // R1/R8/R6: default count 1, everything don't care
        do_arm();
        step(32'h0);
        check(trig_pulse, 1'b1, "R1 default count fires first match");
        check(triggered, 1'b1, "R9 flag set with pulse");
        step(32'h0);
        check(trig_pulse, 1'b0, "R9 pulse one cycle");
        check(triggered, 1'b1, "R10 flag sticky");
        for (int i = 0; i < 3; i++) step(32'hFFFF_0000 >> i);
        check(trig_pulse, 1'b0, "R10 matches ignored after fire");
        check(triggered, 1'b1, "R10 flag still set");

        // R2/R3: level sweep across all channels, both polarities
        for (int c = 0; c < 32; c++) begin
            for (int low = 0; low < 2; low++) begin
                logic [31:0] one, bad, good;
                one  = 32'h1 << c;
                bad  = low ? one : ~one;
                good = ~bad;
                clear_cfg();
                wr(lvl_reg(c), 1 << lvl_bit(c, low));
                do_arm();
                step(bad);
                check(trig_pulse, 1'b0, $sformatf("R2 ch %0d low=%0d wrong level", c, low));
                step(good);
                check(trig_pulse, 1'b1, $sformatf("R3 ch %0d low=%0d right level", c, low));
            end
        end

        // R2: unmapped addresses do nothing
        clear_cfg();
        wr(11, 8'hFF); wr(12, 8'hFF); wr(15, 8'hFF);
        do_arm();
        step(32'h0);
        check(trig_pulse, 1'b1, "R2 writes to 11..15 ignored");

        // R5: edge sweep across all channels and modes
        for (int c = 0; c < 32; c++) begin
            for (int m = 1; m < 4; m++) begin
                logic [31:0] one, decoy;
                one   = 32'h1 << c;
                decoy = 32'h1 << ((c + 1) % 32);
                clear_cfg();
                wr(8, (m << 6) | c);
                step(32'h0);
                do_arm();
                step(decoy);
                check(trig_pulse, 1'b0, $sformatf("R5 ch %0d mode %0d decoy rise", c, m));
                step(32'h0);
                check(trig_pulse, 1'b0, $sformatf("R5 ch %0d mode %0d decoy fall", c, m));
                step(one);
                check(trig_pulse, logic'(m != 2), $sformatf("R5 ch %0d mode %0d rise", c, m));
                do_arm();
                step(32'h0);
                check(trig_pulse, logic'(m != 1), $sformatf("R5 ch %0d mode %0d fall", c, m));
            end
        end

        // R6: mode 00 ignores index bits
        clear_cfg();
        wr(8, 8'h05);
        wr(lvl_reg(3), 1 << lvl_bit(3, 0));
        do_arm();
        step(32'h8);
        check(trig_pulse, 1'b1, "R6 no edge mode, static level fires");

        // R7: edge seen across the arm cycle is not reported afterwards
        clear_cfg();
        wr(8, (1 << 6) | 20);
        step(32'h0);
        @(negedge clk); smp = 32'h1 << 20; arm = 1'b1;
        @(posedge clk); #1; arm = 1'b0;
        step(32'h1 << 20);
        check(trig_pulse, 1'b0, "R7 history updated during arm");
        step(32'h0);
        step(32'h1 << 20);
        check(trig_pulse, 1'b1, "R7 later rise fires");

        // R4: both bits set never matches
        clear_cfg();
        wr(0, 8'h03);
        do_arm();
        for (int i = 0; i < 8; i++) step((i % 2) ? 32'hFFFF_FFFF : 32'h1234_5670 ^ i);
        check(triggered, 1'b0, "R4 contradictory channel never fires");

        // R8/R9: count of three with gaps
        clear_cfg();
        wr(lvl_reg(9), 1 << lvl_bit(9, 0));
        wr(9, 3);
        do_arm();
        begin
            logic [31:0] seq [6];
            int seen;
            seq = '{32'h200, 32'h0, 32'h200, 32'h0, 32'h200, 32'h200};
            seen = 0;
            for (int i = 0; i < 6; i++) begin
                step(seq[i]);
                if (seq[i] != 0) seen++;
                check(trig_pulse, logic'(seen == 3 && seq[i] != 0),
                      $sformatf("R9 count 3 step %0d", i));
            end
        end

        // R8: count zero behaves like one
        wr(9, 0); wr(10, 0);
        do_arm();
        step(32'h200);
        check(trig_pulse, 1'b1, "R8 count 0 fires first match");

        // R8: count 258 uses the high byte
        wr(9, 2); wr(10, 1);
        do_arm();
        begin
            int pulses;
            pulses = 0;
            for (int i = 0; i < 257; i++) begin
                step(32'h200);
                if (trig_pulse) pulses++;
            end
            check(logic'(pulses != 0), 1'b0, "R8 no pulse before 258th match");
        end
        step(32'h200);
        check(trig_pulse, 1'b1, "R8 pulse on 258th match");

        // R10: match held through arm is not counted
        clear_cfg();
        wr(lvl_reg(0), 1);
        wr(9, 2);
        @(negedge clk); smp = 32'h1; arm = 1'b1;
        @(posedge clk); #1; arm = 1'b0;
        step(32'h1);
        check(trig_pulse, 1'b0, "R10 arm-cycle match not counted");
        step(32'h1);
        check(trig_pulse, 1'b1, "R10 second match after arm fires");

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule